// File: doc/BRIEF.md
# Edge-Window Phase Meter

This block turns the timing gap between two binary square waves into a number. A rising edge on the reference input opens a window and a rising edge on the oscillator feedback input closes it. While the window is open, a counter advances once per cycle of a fast sampling clock. The fast clock runs at a large integer multiple of the reference frequency. The result is a count that is proportional to the phase lag of the feedback behind the reference.

Both inputs are asynchronous. Each one passes through a two-stage synchroniser. An edge is found by comparing the newest synchronised sample with the sample before it. The two inputs see the same synchroniser delay, so that delay adds no bias to the count.

Each reference rising edge does three things at once. It clears the counter for the new period, it copies the finished count to the output word, and it raises a single-cycle valid strobe. The open/closed window state is also brought out, so a loop filter that works on levels can use it directly.

Top module: `phase_window_meter`

## Requirements
- R1: A reference rising edge sets the window. With the input changed between clock edges, `window_o` reads 1 after the third rising clock edge that follows the change.
- R2: A feedback rising edge clears the window, with the same three-edge latency as R1.
- R3: Input levels have no effect on the window. A reference held high does not reopen a window that the feedback edge has closed. A feedback held high does not close a window again once a reference edge has opened it.
- R4: The counter advances by one on every clock edge at which the window is open. When a reference edge is detected, the counter value is copied to `err_o` and the counter restarts from 0. With one reference edge and one feedback edge per period, `err_o` equals the delay between them, counted in fast-clock cycles.
- R5: `err_valid_o` is a one-cycle pulse for each reference rising edge. It is high in the same cycle that `err_o` takes its new value. `err_o` does not change in any other cycle.
- R6: When a reference edge and a feedback edge are detected in the same cycle, the set wins and the window opens. With coincident edges every period, the window never closes, and `err_o` reads period−1.
- R7: The counter stops at 2^CNT_W−1 (255 for the default width) and does not wrap. A period with no feedback edge that is longer than this reports 255.
- R8: While reset is high and after it is released, all outputs read 0 until the first reference edge is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Asynchronous reference square wave |
| fb_in | input | 1 | Asynchronous feedback square wave from the oscillator |
| err_o | output | CNT_W | Count from the last completed reference period |
| err_valid_o | output | 1 | One-cycle strobe marking a new `err_o` |
| window_o | output | 1 | Current window state (1 = open) |

## Verification
The checker watches the window-update rules on every cycle. These are set priority, clearing by feedback, and holding when no edge is present. It also checks on every cycle that the counter restarts at each reference edge, that the counter holds at its ceiling, that the strobe is a single pulse, and that the error word stays stable between strobes. Some behaviour shows only under the bench's stimulus, because it depends on real input waveforms: the three-cycle input latency, the equality between the latched count and the programmed edge delay, the period−1 reading under coincident edges, and the 255 reading when feedback is missing. A behavioural model in the bench follows every cycle of all these scenarios.

// File: rtl/phase_window_meter_pkg.sv
package phase_window_meter_pkg;

    typedef enum logic {
        WIN_SHUT = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_t;

    typedef struct packed {
        logic ref_rise;
        logic fb_rise;
    } edge_pair_t;

    localparam int unsigned SYNC_DEPTH_DEF = 2;
    localparam int unsigned CNT_W_DEF      = 8;

endpackage

// File: rtl/pwm_edge_sync.sv
module pwm_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int unsigned TAPS = STAGES + 1;

    logic [TAPS-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[TAPS-2:0], din};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/pwm_window.sv
module pwm_window
    import phase_window_meter_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  edge_pair_t edges,
    output logic       window
);
    win_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (edges.ref_rise)     st_d = WIN_OPEN;
        else if (edges.fb_rise) st_d = WIN_SHUT;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= WIN_SHUT;
        else     st_q <= st_d;
    end

    assign window = (st_q == WIN_OPEN);
endmodule

// File: rtl/pwm_gate_count.sv
module pwm_gate_count #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             window,
    input  logic             restart,
    output logic [CNT_W-1:0] run_cnt,
    output logic [CNT_W-1:0] err,
    output logic             valid
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q, err_q;
    logic             valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            err_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= restart;
            if (restart) begin
                err_q <= cnt_q;
                cnt_q <= '0;
            end else if (window && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign run_cnt = cnt_q;
    assign err     = err_q;
    assign valid   = valid_q;
endmodule

// File: rtl/phase_window_meter.sv
module phase_window_meter
    import phase_window_meter_pkg::*;
#(
    parameter int unsigned CNT_W      = CNT_W_DEF,
    parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             fb_in,
    output logic [CNT_W-1:0] err_o,
    output logic             err_valid_o,
    output logic             window_o
);
    localparam int unsigned NUM_IN = 2;

    logic [NUM_IN-1:0] raw_in, rise_vec;
    edge_pair_t        edges;
    logic [CNT_W-1:0]  run_cnt;

    assign raw_in = {ref_in, fb_in};

    generate
        for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
            pwm_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .din  (raw_in[g]),
                .rise (rise_vec[g])
            );
        end
    endgenerate

    assign edges.ref_rise = rise_vec[1];
    assign edges.fb_rise  = rise_vec[0];

    pwm_window u_win (
        .clk    (clk),
        .rst    (rst),
        .edges  (edges),
        .window (window_o)
    );

    pwm_gate_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .window  (window_o),
        .restart (edges.ref_rise),
        .run_cnt (run_cnt),
        .err     (err_o),
        .valid   (err_valid_o)
    );
endmodule

// File: rtl/phase_window_meter_chk.sv
module phase_window_meter_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_rise,
    input logic             fb_rise,
    input logic             window,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] err,
    input logic             valid
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    a_r1_set_opens: assert property (@(posedge clk) disable iff (rst)
        ref_rise |=> window);

    a_r2_clear_closes: assert property (@(posedge clk) disable iff (rst)
        (fb_rise && !ref_rise) |=> !window);

    a_r3_level_hold: assert property (@(posedge clk) disable iff (rst)
        (!ref_rise && !fb_rise) |=> (window == $past(window)));

    a_r4_restart_zero: assert property (@(posedge clk) disable iff (rst)
        ref_rise |=> (cnt == '0));

    a_r5_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        ref_rise |=> valid);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    a_r5_err_steady: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(err));

    a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !ref_rise) |=> (cnt == CNT_MAX));
endmodule

bind phase_window_meter phase_window_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (edges.ref_rise),
    .fb_rise  (edges.fb_rise),
    .window   (window_o),
    .cnt      (run_cnt),
    .err      (err_o),
    .valid    (err_valid_o)
);

// File: tb/sim_phase_window_meter.sv
`timescale 1ns/1ps
module sim_phase_window_meter;
    localparam int W   = 8;
    localparam int MAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ref_in = 1'b0;
    logic         fb_in = 1'b0;
    logic [W-1:0] err_o;
    logic         err_valid_o;
    logic         window_o;

    int n_chk = 0, n_bad = 0, cyc = 0, n_valid = 0, last_err = -1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    phase_window_meter #(.CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .err_o(err_o), .err_valid_o(err_valid_o), .window_o(window_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural model: input histories, newest first
    bit hr[$], hf[$];
    bit m_win, m_v;
    int m_cnt, m_err;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            hr = '{0, 0, 0}; hf = '{0, 0, 0};
            m_win = 0; m_v = 0; m_cnt = 0; m_err = 0;
        end else begin
            bit r, f;
            r = hr[1] && !hr[2];
            f = hf[1] && !hf[2];
            m_v = r;
            if (r) begin m_err = m_cnt; m_cnt = 0; end
            else if (m_win && m_cnt < MAX) m_cnt++;
            if (r) m_win = 1; else if (f) m_win = 0;
            hr.push_front(ref_in); void'(hr.pop_back());
            hf.push_front(fb_in);  void'(hf.pop_back());
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(window_o == m_win, "R1/R2 window", int'(window_o), int'(m_win));
            chk(err_valid_o == m_v, "R5 strobe", int'(err_valid_o), int'(m_v));
            chk(int'(err_o) == m_err, "R4 err word", int'(err_o), m_err);
            if (err_valid_o) begin n_valid++; last_err = int'(err_o); end
        end
    end

    task automatic run_period(input int period, input int dly, input bit fb_on, input int win_end);
        for (int i = 0; i < period; i++) begin
            @(negedge clk);
            ref_in = (i < period / 2);
            fb_in  = fb_on && (i >= dly) && (i < dly + period / 2);
            if (i == 3 && dly > 3)
                chk(window_o == 1'b1, "R1 opens after three edges", int'(window_o), 1);
            if (i == period - 1)
                chk(window_o == win_end[0], "R3/R6 window at period end", int'(window_o), win_end);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(err_o == '0 && !err_valid_o && !window_o, "R8 outputs during reset",
            int'({err_o, err_valid_o, window_o}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(err_o == '0 && !err_valid_o && !window_o, "R8 outputs after reset",
            int'({err_o, err_valid_o, window_o}), 0);

        for (int k = 0; k < 3; k++) run_period(40, 5, 1'b1, 0);
        chk(last_err == 5, "R4 delay 5", last_err, 5);

        for (int k = 0; k < 3; k++) run_period(40, 17, 1'b1, 0);
        chk(last_err == 17, "R4 delay 17", last_err, 17);

        for (int k = 0; k < 3; k++) run_period(60, 30, 1'b1, 0);
        chk(last_err == 30, "R2 R4 delay 30", last_err, 30);

        for (int k = 0; k < 3; k++) run_period(40, 0, 1'b1, 1);
        chk(last_err == 39, "R6 coincident edges", last_err, 39);

        for (int k = 0; k < 3; k++) run_period(400, 0, 1'b0, 1);
        chk(last_err == MAX, "R7 saturation", last_err, MAX);

        repeat (6) @(negedge clk);
        chk(n_valid == 15, "R5 one strobe per reference edge", n_valid, 15);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule